// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

A local interrupt timer for a processor core. Software programs a 32-bit start value, a divide code and a timer control entry through a small synchronous register port. The counter then steps down by one on every divided clock tick. When it reaches zero, the timer posts an interrupt request that carries the entry's 8-bit vector, unless the entry is masked. In one-shot mode the count then stops. In periodic mode it reloads from the start value and keeps running. The request stays raised until the core acknowledges it. Expiries that arrive before the acknowledge merge into a single pending flag.

Besides the timer entry, the block holds a small table of further vector entries, each with a vector and a mask bit. A global enable bit acts as a software kill switch: clearing it masks every entry at once, and while it is clear any entry written comes back masked.

Top module: `cdtimer`

## Requirements
- R1: Reset state. Control (addr 0, enable in bit 0) reads 0, start value (addr 1) reads 0, current count (addr 2) reads 0, and every entry (addr 4 + i, vector in bits 7:0, mask in bit 16, periodic-mode bit in bit 17 of entry 0 only) reads with its mask bit set. `irq` is low.
- R2: The divide code (addr 3, bits 3:0) selects a tick ratio of 2^(({d3,d1,d0}+1) mod 8). Bit 2 has no effect. After a start-value write of V, the request rises on the V×ratio-th clock edge after the write edge.
- R3: Writing the start value abandons any running count, loads the new value, restarts the prescaler and clears the pending request.
- R4: A start value of 0 stops the timer. No request is raised, and the current count reads 0.
- R5: In one-shot mode (bit 17 = 0) the count stops at 0 after expiry and stays there.
- R6: In periodic mode (bit 17 = 1) expiry reloads the start value in the same edge, so counting continues and the request recurs every V×ratio cycles.
- R7: An expiry while entry 0 is masked raises no request.
- R8: The request stays high, with `irq_vec` equal to the entry 0 vector, until a cycle with `irq_ack` high. Repeated expiries before that acknowledge leave a single pending flag, which one acknowledge clears.
- R9: Writing entry 0 with a mode bit different from the stored one halts counting and freezes the current count. A write with the same mode lets counting continue.
- R10: Writing control with bit 0 = 0 sets the mask bit of every entry and clears the pending request. While enable is 0, any entry write stores its mask bit as 1.
- R11: A divide-code write takes effect at the next prescaler rollover. The tick in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_ack | input | 1 | Acknowledge; clears the pending request |
| irq | output | 1 | Interrupt request, held until acknowledged |
| irq_vec | output | VEC_W | Vector of the timer entry |

## Verification
A start-value write lands on clock edge E0, which resets the prescaler. A tick falls on every ratio-th edge after that, so the count read back after edge Ek is V − floor(k/ratio) and the request is first visible after edge E(V×ratio). Acknowledges, disables and restarts take effect on their own write edge. The bench drives and samples on falling edges and counts falling edges from the write to the exact sample points: it checks the request low one cycle before it is due and high on the cycle it is due. The divide change is aimed at a point inside a tick, so that a one-cycle early switch to the new ratio would move the expiry and show up in the check.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_INIT = 1;
   localparam int ADDR_CUR  = 2;
   localparam int ADDR_DIV  = 3;
   localparam int ADDR_ENT0 = 4;
   localparam int MASK_BIT  = 16;
   localparam int MODE_BIT  = 17;
   localparam int DIV_LOG_MAX = 7;

   function automatic logic [2:0] div_shift(input logic [3:0] code);
      return {code[3], code[1:0]} + 3'd1;
   endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
   parameter int PRE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic [3:0] div_code,
   output logic       tick
);
   logic [PRE_W-1:0] pre_q;
   logic [2:0]       shift_q;
   logic [PRE_W-1:0] lim;

   assign lim  = ~({PRE_W{1'b1}} << shift_q);
   assign tick = run && (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         shift_q <= 3'd1;
      end else if (restart) begin
         pre_q   <= '0;
         shift_q <= cdt_pkg::div_shift(div_code);
      end else if (run) begin
         if (tick) begin
            pre_q   <= '0;
            shift_q <= cdt_pkg::div_shift(div_code);
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             periodic,
   input  logic             cancel,
   output logic [CNT_W-1:0] cur,
   output logic             running,
   output logic             expire
);
   logic at_one;
   assign at_one = (cur == CNT_W'(1));
   assign expire = tick && running && at_one && !load && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= '0;
         running <= 1'b0;
      end else if (load) begin
         cur     <= load_val;
         running <= |load_val;
      end else if (cancel) begin
         running <= 1'b0;
      end else if (tick && running) begin
         if (at_one) begin
            if (periodic) begin
               cur <= reload_val;
            end else begin
               cur     <= '0;
               running <= 1'b0;
            end
         end else begin
            cur <= cur - 1'b1;
         end
      end
   end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs #(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int N_ENT  = 6,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cur,
   output logic [DATA_W-1:0] rdata,
   output logic              enable,
   output logic [CNT_W-1:0]  init_q,
   output logic [3:0]        div_q,
   output logic              init_wr,
   output logic              disable_wr,
   output logic              mode_change,
   output logic [VEC_W-1:0]  t_vec,
   output logic              t_mask,
   output logic              t_periodic,
   output logic [N_ENT-1:0]  masks
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(cdt_pkg::ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(cdt_pkg::ADDR_INIT);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(cdt_pkg::ADDR_CUR);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(cdt_pkg::ADDR_DIV);
   localparam logic [ADDR_W-1:0] A_ENT0 = ADDR_W'(cdt_pkg::ADDR_ENT0);

   logic [DATA_W-1:0] ent_word [N_ENT];

   assign init_wr     = wr && (addr == A_INIT);
   assign disable_wr  = wr && (addr == A_CTRL) && !wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         init_q <= '0;
         div_q  <= '0;
      end else if (wr) begin
         if (addr == A_CTRL) enable <= wdata[0];
         if (addr == A_INIT) init_q <= wdata[CNT_W-1:0];
         if (addr == A_DIV)  div_q  <= wdata[3:0];
      end
   end

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      logic [VEC_W-1:0] vec_q;
      logic             mask_q;
      logic             mode_bit;
      logic             hit;
      assign hit = wr && (addr == ADDR_W'(cdt_pkg::ADDR_ENT0 + i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_q  <= '0;
            mask_q <= 1'b1;
         end else if (disable_wr) begin
            mask_q <= 1'b1;
         end else if (hit) begin
            vec_q  <= wdata[VEC_W-1:0];
            mask_q <= wdata[cdt_pkg::MASK_BIT] | ~enable;
         end
      end

      if (i == 0) begin : g_mode
         logic mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mode_q <= 1'b0;
            else if (hit) mode_q <= wdata[cdt_pkg::MODE_BIT];
         end
         assign mode_bit = mode_q;
      end else begin : g_nomode
         assign mode_bit = 1'b0;
      end

      always_comb begin
         ent_word[i] = '0;
         ent_word[i][VEC_W-1:0] = vec_q;
         ent_word[i][cdt_pkg::MASK_BIT] = mask_q;
         ent_word[i][cdt_pkg::MODE_BIT] = mode_bit;
      end
      assign masks[i] = mask_q;
   end

   assign t_vec      = g_ent[0].vec_q;
   assign t_mask     = g_ent[0].mask_q;
   assign t_periodic = g_ent[0].mode_bit;
   assign mode_change = wr && (addr == A_ENT0) &&
                        (wdata[cdt_pkg::MODE_BIT] != t_periodic);

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:  rdata[0] = enable;
         A_INIT:  rdata[CNT_W-1:0] = init_q;
         A_CUR:   rdata[CNT_W-1:0] = cur;
         A_DIV:   rdata[3:0] = div_q;
         default: rdata = '0;
      endcase
      for (int i = 0; i < N_ENT; i++) begin
         if (addr == ADDR_W'(cdt_pkg::ADDR_ENT0 + i)) rdata = ent_word[i];
      end
   end
endmodule

// File: rtl/cdtimer.sv
module cdtimer #(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int N_ENT  = 6,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              irq_ack,
   output logic              irq,
   output logic [VEC_W-1:0]  irq_vec
);
   localparam int PRE_W = cdt_pkg::DIV_LOG_MAX;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("cdtimer: CNT_W must lie in 2..DATA_W");
   end
   if (VEC_W < 1 || VEC_W > cdt_pkg::MASK_BIT) begin : g_bad_vec
      $error("cdtimer: VEC_W must lie below the mask bit");
   end
   if (N_ENT < 1 || cdt_pkg::ADDR_ENT0 + N_ENT > (1 << ADDR_W)) begin : g_bad_ent
      $error("cdtimer: entry table does not fit the address space");
   end
   if (DATA_W <= cdt_pkg::MODE_BIT) begin : g_bad_data
      $error("cdtimer: DATA_W too narrow for the entry layout");
   end

   logic             enable, init_wr, disable_wr, mode_change;
   logic [CNT_W-1:0] init_q, cur_q;
   logic [3:0]       div_q;
   logic [VEC_W-1:0] t_vec;
   logic             t_mask, t_periodic;
   logic [N_ENT-1:0] ent_masks;
   logic             tick, running, expire, pend_q;

   cdt_regs #(
      .CNT_W(CNT_W), .VEC_W(VEC_W), .N_ENT(N_ENT),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .cur(cur_q), .rdata(reg_rdata),
      .enable(enable), .init_q(init_q), .div_q(div_q),
      .init_wr(init_wr), .disable_wr(disable_wr), .mode_change(mode_change),
      .t_vec(t_vec), .t_mask(t_mask), .t_periodic(t_periodic),
      .masks(ent_masks)
   );

   cdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(init_wr), .run(running),
      .div_code(div_q), .tick(tick)
   );

   cdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(init_wr),
      .load_val(reg_wdata[CNT_W-1:0]), .reload_val(init_q),
      .tick(tick), .periodic(t_periodic), .cancel(mode_change),
      .cur(cur_q), .running(running), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pend_q <= 1'b0;
      else if (init_wr || disable_wr)   pend_q <= 1'b0;
      else if (expire && !t_mask)       pend_q <= 1'b1;
      else if (irq_ack)                 pend_q <= 1'b0;
   end

   assign irq     = pend_q;
   assign irq_vec = t_vec;
endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk #(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int N_ENT  = 6,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq_ack,
   input logic              irq,
   input logic [VEC_W-1:0]  irq_vec,
   input logic              en,
   input logic [CNT_W-1:0]  init_q,
   input logic [CNT_W-1:0]  cur,
   input logic              running,
   input logic              t_mask,
   input logic [N_ENT-1:0]  masks
);
   logic wr_init, wr_ent0, wr_off;
   assign wr_init = reg_wr && (reg_addr == ADDR_W'(cdt_pkg::ADDR_INIT));
   assign wr_ent0 = reg_wr && (reg_addr == ADDR_W'(cdt_pkg::ADDR_ENT0));
   assign wr_off  = reg_wr && (reg_addr == ADDR_W'(cdt_pkg::ADDR_CTRL)) && !reg_wdata[0];

   assert_zero_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (init_q == '0) |-> (cur == '0));

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !wr_init) |=>
         (cur == $past(cur) || cur == $past(cur) - 1'b1 || cur == init_q));

   assert_stopped_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !wr_init) |=> $stable(cur));

   assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack && !wr_init && !wr_off) |=> irq);

   assert_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_ent0) |=> $stable(irq_vec));

   assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !$past(t_mask));

   assert_off_masks_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (masks == {N_ENT{1'b1}}));

   assert_off_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_off |=> !irq);
endmodule

bind cdtimer cdtimer_chk #(
   .CNT_W(CNT_W), .VEC_W(VEC_W), .N_ENT(N_ENT),
   .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq_ack(irq_ack), .irq(irq), .irq_vec(irq_vec),
   .en(enable), .init_q(init_q), .cur(cur_q), .running(running),
   .t_mask(t_mask), .masks(ent_masks)
);

// File: tb/sim_cdtimer.sv
module sim_cdtimer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_ack = 1'b0;
   logic        irq;
   logic [7:0]  irq_vec;
   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] rv;

   localparam logic [31:0] PER = 32'h0002_0000;
   localparam logic [31:0] MSK = 32'h0001_0000;

   always #4 clk = ~clk;

   cdtimer u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
      .irq(irq), .irq_vec(irq_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_ack = 1'b0;
   endtask

   function automatic int ratio(input logic [3:0] d);
      int k;
      k = (int'({d[3], d[1:0]}) + 1) % 8;
      return 1 << k;
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      waitn(3);
      rst_n = 1'b1;
      waitn(1);
      // R1 reset state
      rd(4'd2, rv); chk("R1 cur", rv, 0);
      rd(4'd0, rv); chk("R1 ctrl", rv, 0);
      rd(4'd1, rv); chk("R1 init", rv, 0);
      for (int i = 0; i < 6; i++) begin
         rd(4'(4 + i), rv); chk("R1 entry mask", rv & MSK, MSK);
      end
      chk("R1 irq", {31'b0, irq}, 0);

      wr(4'd0, 32'd1);
      wr(4'd4, 32'h41);
      // R2 sweep of every divide code, V = 3
      for (int d = 0; d < 16; d++) begin
         int n;
         n = 3 * ratio(4'(d));
         wr(4'd3, 32'(d));
         wr(4'd1, 32'd3);
         waitn(n - 1);
         chk("R2 early", {31'b0, irq}, 0);
         waitn(1);
         chk("R2 due", {31'b0, irq}, 1);
         chk("R8 vec", {24'b0, irq_vec}, 32'h41);
         rd(4'd2, rv); chk("R5 cur zero", rv, 0);
         ack();
         chk("R8 ack clears", {31'b0, irq}, 0);
      end
      wr(4'd3, 32'hB);
      waitn(10);
      chk("R5 stays stopped", {31'b0, irq}, 0);
      rd(4'd2, rv); chk("R5 cur stays 0", rv, 0);

      // R8 held until acknowledge
      wr(4'd1, 32'd2);
      waitn(2);
      chk("R8 raised", {31'b0, irq}, 1);
      waitn(20);
      chk("R8 held", {31'b0, irq}, 1);
      ack();
      chk("R8 dropped", {31'b0, irq}, 0);

      // R6 periodic, ratio 2, V = 4
      wr(4'd3, 32'h0);
      wr(4'd4, PER | 32'h52);
      wr(4'd1, 32'd4);
      waitn(7);
      chk("R6 early", {31'b0, irq}, 0);
      waitn(1);
      chk("R6 first", {31'b0, irq}, 1);
      chk("R8 vec periodic", {24'b0, irq_vec}, 32'h52);
      rd(4'd2, rv); chk("R6 reload", rv, 4);
      ack();
      waitn(6);
      chk("R6 before second", {31'b0, irq}, 0);
      waitn(1);
      chk("R6 second", {31'b0, irq}, 1);
      ack();

      // R8 no accumulation, ratio 1, V = 2
      wr(4'd3, 32'hB);
      wr(4'd1, 32'd2);
      waitn(4);
      chk("R8 pending", {31'b0, irq}, 1);
      ack();
      chk("R8 single ack clears merged", {31'b0, irq}, 0);
      waitn(1);
      chk("R6 recur", {31'b0, irq}, 1);
      ack();
      // R4 stop with zero
      wr(4'd1, 32'd0);
      chk("R4 irq cleared", {31'b0, irq}, 0);
      rd(4'd2, rv); chk("R4 cur", rv, 0);
      waitn(10);
      chk("R4 no irq", {31'b0, irq}, 0);

      // R3 restart
      wr(4'd4, 32'h41);
      wr(4'd1, 32'd10);
      waitn(5);
      rd(4'd2, rv); chk("R3 midcount", rv, 5);
      wr(4'd1, 32'd6);
      waitn(5);
      chk("R3 not old expiry", {31'b0, irq}, 0);
      waitn(1);
      chk("R3 new expiry", {31'b0, irq}, 1);
      wr(4'd1, 32'd50);
      chk("R3 pending cleared", {31'b0, irq}, 0);
      rd(4'd2, rv); chk("R3 loaded", rv, 50);

      // R9 mode change cancels
      waitn(3);
      rd(4'd2, rv); chk("R9 before", rv, 47);
      wr(4'd4, PER | 32'h41);
      rd(4'd2, rv); chk("R9 frozen", rv, 47);
      waitn(60);
      rd(4'd2, rv); chk("R9 still frozen", rv, 47);
      chk("R9 no irq", {31'b0, irq}, 0);
      wr(4'd1, 32'd5);
      wr(4'd4, PER | 32'h43);
      waitn(3);
      chk("R9 same mode early", {31'b0, irq}, 0);
      waitn(1);
      chk("R9 same mode runs", {31'b0, irq}, 1);
      chk("R9 new vector", {24'b0, irq_vec}, 32'h43);

      // R4 zero written mid count
      wr(4'd1, 32'd20);
      waitn(3);
      wr(4'd1, 32'd0);
      rd(4'd2, rv); chk("R4 mid cur", rv, 0);
      waitn(30);
      chk("R4 mid no irq", {31'b0, irq}, 0);

      // R10 software disable
      wr(4'd1, 32'd2);
      waitn(2);
      chk("R10 pre irq", {31'b0, irq}, 1);
      wr(4'd0, 32'd0);
      chk("R10 irq cleared", {31'b0, irq}, 0);
      for (int i = 0; i < 6; i++) begin
         rd(4'(4 + i), rv); chk("R10 forced mask", rv & MSK, MSK);
      end
      wr(4'd6, 32'h77);
      rd(4'd6, rv); chk("R10 write while off", rv, MSK | 32'h77);
      waitn(20);
      chk("R7 masked while off", {31'b0, irq}, 0);
      wr(4'd0, 32'd1);
      wr(4'd1, 32'd3);
      waitn(10);
      chk("R7 masked entry", {31'b0, irq}, 0);
      rd(4'd4, rv); chk("R7 entry kept", rv, PER | MSK | 32'h43);

      // R11 divide change at rollover
      wr(4'd4, 32'h41);
      wr(4'd3, 32'h2);
      wr(4'd1, 32'd3);
      wr(4'd3, 32'hB);
      waitn(7);
      rd(4'd2, rv); chk("R11 first tick old ratio", rv, 2);
      chk("R11 early", {31'b0, irq}, 0);
      waitn(1);
      chk("R11 second tick", {31'b0, irq}, 0);
      waitn(1);
      chk("R11 expiry new ratio", {31'b0, irq}, 1);
      ack();

      summary();
      $finish;
   end
endmodule